// File: doc/BRIEF.md
# Measurement Cycle Sequencer

This block decides which analog source a converter digitises next. For each step it drives a select code for the input multiplexer and a tag for the kind of measurement. It raises a one-cycle start request and then waits for a one-cycle completion pulse before it moves on. The ADC, the correction arithmetic and the multiplexer are outside the block. The sequencer only produces select codes, tags and the request/completion handshake.

After reset a short start routine takes a first reading of each quantity the loop needs. The block then runs a loop pass without end. In the loop, groups of bridge readings are interleaved between the single auto-zero and temperature steps. The group size is a power of two from 1 to 128, and an optional branch adds a second temperature channel. The group size, the branch enable and the first-temperature source are captured once per pass. A change made mid-pass therefore never breaks the order. The step tag lets downstream logic send each result to the right register.

Top module: `measure_cycle_seq`

## Requirements
- R1: While `rst` is high, `conv_start` is 0. After the first rising edge with `rst` low, `conv_start` is 1 in the following cycle.
- R2: `conv_start` is high for exactly one cycle. The block then waits. The next `conv_start` comes in the cycle after the edge that samples `conv_done` high during the wait, and at no other time.
- R3: `conv_src` and `step_kind` stay constant from the start cycle until `conv_done` is accepted.
- R4: The start routine order is: bridge reading, bridge auto-zero, temperature-1 auto-zero, temperature-1 reading. When the branch enable is 1, it then adds temperature-2 auto-zero and temperature-2 reading. The first loop pass follows directly.
- R5: One loop pass runs the following steps in order:
  - G bridge readings, temperature-1 auto-zero;
  - G bridge readings, temperature-1 reading;
  - G bridge readings, bridge auto-zero;
  - when the branch enable is 1: G bridge readings, temperature-2 auto-zero, temperature-2 reading, G bridge readings.
- R6: With the branch enable at 0, the pass goes from the bridge auto-zero straight back to the first group. No temperature-2 step ever appears and no extra cycle is spent.
- R7: The group size G is 2^`cfg_rep_sel` (1, 2, 4, …, 128 for a 3-bit select).
- R8: The group size, the branch enable and the temperature-1 source are captured during reset and at the acceptance of the last step before each pass begins. Changes at other times take effect only from the next pass.
- R9: The source codes are:
  - every bridge reading: 0 (bridge amplifier);
  - every auto-zero: 1 (shorted input);
  - temperature-2: 5 (external thermistor);
  - temperature-1, set by `cfg_t1_src`: 0→2 (external diode), 1→3 (internal junction), 2→4 (bridge resistance), 3→2.
- R10: The `step_kind` codes are: 0 bridge reading, 1 bridge auto-zero, 2 temperature-1 auto-zero, 3 temperature-1 reading, 4 temperature-2 auto-zero, 5 temperature-2 reading.
- R11: A `conv_done` pulse outside the wait (in idle or in the start cycle) is ignored. It neither advances the step nor produces an extra start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rep_sel | input | N_SEL_W | Log2 of the bridge group size |
| cfg_temp2_en | input | 1 | Enables the temperature-2 branch |
| cfg_t1_src | input | 2 | Temperature-1 source choice |
| conv_done | input | 1 | Conversion completion pulse |
| conv_start | output | 1 | One-cycle conversion request |
| conv_src | output | 3 | Multiplexer source code |
| step_kind | output | 3 | Tag of the current step |

## Verification
The first request is due one cycle after the first edge with reset low. After that, each request is due exactly one cycle after the edge that sees the completion pulse during the wait. The select code and tag are due with the request and must hold until acceptance. A configuration change first shows in the step issued after the pass's last step is accepted. The bench keeps a behavioural queue of expected steps, rebuilt from the configuration present at that same edge. It drives inputs and compares all outputs at the falling edge, so every comparison sees values settled by the preceding rising edge. Completion latency is random, stray completion pulses are injected in one phase, and every group size and temperature-1 source is covered.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

    localparam int SRC_W    = 3;
    localparam int KIND_W   = 3;
    localparam int T1_SEL_W = 2;
    localparam int POS_W    = 4;

    // step tags seen downstream
    typedef enum logic [KIND_W-1:0] {
        K_PRESS    = 3'd0,
        K_AZ_PRESS = 3'd1,
        K_AZ_T1    = 3'd2,
        K_TEMP1    = 3'd3,
        K_AZ_T2    = 3'd4,
        K_TEMP2    = 3'd5
    } step_kind_e;

    // multiplexer source codes
    localparam logic [SRC_W-1:0] SRC_BRIDGE     = 3'd0;
    localparam logic [SRC_W-1:0] SRC_SHORT      = 3'd1;
    localparam logic [SRC_W-1:0] SRC_EXT_DIODE  = 3'd2;
    localparam logic [SRC_W-1:0] SRC_JUNCTION   = 3'd3;
    localparam logic [SRC_W-1:0] SRC_BRIDGE_RES = 3'd4;
    localparam logic [SRC_W-1:0] SRC_THERMISTOR = 3'd5;

    // program positions: start routine then loop pass
    localparam logic [POS_W-1:0] POS_S0 = 4'd0;
    localparam logic [POS_W-1:0] POS_S1 = 4'd1;
    localparam logic [POS_W-1:0] POS_S2 = 4'd2;
    localparam logic [POS_W-1:0] POS_S3 = 4'd3;
    localparam logic [POS_W-1:0] POS_S4 = 4'd4;
    localparam logic [POS_W-1:0] POS_S5 = 4'd5;
    localparam logic [POS_W-1:0] POS_L0 = 4'd6;
    localparam logic [POS_W-1:0] POS_L1 = 4'd7;
    localparam logic [POS_W-1:0] POS_L2 = 4'd8;
    localparam logic [POS_W-1:0] POS_L3 = 4'd9;
    localparam logic [POS_W-1:0] POS_L4 = 4'd10;
    localparam logic [POS_W-1:0] POS_L5 = 4'd11;
    localparam logic [POS_W-1:0] POS_L6 = 4'd12;
    localparam logic [POS_W-1:0] POS_L7 = 4'd13;
    localparam logic [POS_W-1:0] POS_L8 = 4'd14;
    localparam logic [POS_W-1:0] POS_L9 = 4'd15;

    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_ISSUE = 2'd1,
        HS_WAIT  = 2'd2
    } hs_state_e;

    typedef struct packed {
        step_kind_e kind;
        logic       grouped;
    } slot_info_t;

    function automatic logic [SRC_W-1:0] t1_code(input logic [T1_SEL_W-1:0] sel);
        case (sel)
            2'd1:    return SRC_JUNCTION;
            2'd2:    return SRC_BRIDGE_RES;
            default: return SRC_EXT_DIODE;
        endcase
    endfunction

    function automatic logic [SRC_W-1:0] src_for(input step_kind_e k,
                                                  input logic [T1_SEL_W-1:0] sel);
        case (k)
            K_PRESS:                      return SRC_BRIDGE;
            K_AZ_PRESS, K_AZ_T1, K_AZ_T2: return SRC_SHORT;
            K_TEMP1:                      return t1_code(sel);
            default:                      return SRC_THERMISTOR;
        endcase
    endfunction

endpackage

// File: rtl/mcs_handshake.sv
module mcs_handshake
    import mcs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic conv_done,
    output logic conv_start,
    output logic waiting,
    output logic accept
);

    hs_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            HS_IDLE:  state_d = HS_ISSUE;
            HS_ISSUE: state_d = HS_WAIT;
            HS_WAIT:  if (conv_done) state_d = HS_ISSUE;
            default:  state_d = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= HS_IDLE;
        else     state_q <= state_d;
    end

    assign conv_start = (state_q == HS_ISSUE);
    assign waiting    = (state_q == HS_WAIT);
    assign accept     = waiting && conv_done;

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start); // R2
    AST_DONE_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        (waiting && conv_done) |=> conv_start); // R2
    AST_HOLD_NO_START: assert property (@(posedge clk) disable iff (rst)
        (waiting && !conv_done) |=> !conv_start); // R11

endmodule

// File: rtl/mcs_slot_map.sv
module mcs_slot_map
    import mcs_pkg::*;
(
    input  logic [POS_W-1:0] pos,
    input  logic             e2,
    output slot_info_t       info,
    output logic [POS_W-1:0] pos_nxt,
    output logic             wrap
);

    always_comb begin
        info.grouped = 1'b0;
        info.kind    = K_PRESS;
        case (pos)
            POS_S0: info.kind = K_PRESS;
            POS_S1: info.kind = K_AZ_PRESS;
            POS_S2: info.kind = K_AZ_T1;
            POS_S3: info.kind = K_TEMP1;
            POS_S4: info.kind = K_AZ_T2;
            POS_S5: info.kind = K_TEMP2;
            POS_L1: info.kind = K_AZ_T1;
            POS_L3: info.kind = K_TEMP1;
            POS_L5: info.kind = K_AZ_PRESS;
            POS_L7: info.kind = K_AZ_T2;
            POS_L8: info.kind = K_TEMP2;
            default: begin
                info.kind    = K_PRESS;
                info.grouped = 1'b1;
            end
        endcase
    end

    always_comb begin
        pos_nxt = pos + POS_W'(1);
        case (pos)
            POS_S3:  pos_nxt = e2 ? POS_S4 : POS_L0;
            POS_L5:  pos_nxt = e2 ? POS_L6 : POS_L0;
            POS_L9:  pos_nxt = POS_L0;
            default: ;
        endcase
    end

    assign wrap = (pos_nxt == POS_L0);

endmodule

// File: rtl/mcs_repeat_ctr.sv
module mcs_repeat_ctr #(
    parameter int N_SEL_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bump,
    input  logic [N_SEL_W-1:0] n_sel,
    output logic               last
);

    localparam int CNT_W = (1 << N_SEL_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    assign limit = (CNT_W'(1) << n_sel) - CNT_W'(1);
    assign last  = (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (bump) cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
    end

    AST_REP_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= limit); // R7

endmodule

// File: rtl/measure_cycle_seq.sv
module measure_cycle_seq
    import mcs_pkg::*;
#(
    parameter int N_SEL_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_SEL_W-1:0] cfg_rep_sel,
    input  logic               cfg_temp2_en,
    input  logic [1:0]         cfg_t1_src,
    input  logic               conv_done,
    output logic               conv_start,
    output logic [2:0]         conv_src,
    output logic [2:0]         step_kind
);

    logic [POS_W-1:0]    pos_q, pos_nxt;
    logic                wrap;
    slot_info_t          info;
    logic [N_SEL_W-1:0]  nsel_q;
    logic                e2_q;
    logic [T1_SEL_W-1:0] t1_q;
    logic                accept, waiting, rep_last, move;

    mcs_handshake u_hs (
        .clk        (clk),
        .rst        (rst),
        .conv_done  (conv_done),
        .conv_start (conv_start),
        .waiting    (waiting),
        .accept     (accept)
    );

    mcs_slot_map u_map (
        .pos     (pos_q),
        .e2      (e2_q),
        .info    (info),
        .pos_nxt (pos_nxt),
        .wrap    (wrap)
    );

    mcs_repeat_ctr #(.N_SEL_W(N_SEL_W)) u_rep (
        .clk   (clk),
        .rst   (rst),
        .bump  (accept && info.grouped),
        .n_sel (nsel_q),
        .last  (rep_last)
    );

    assign move = accept && (!info.grouped || rep_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= POS_S0;
            nsel_q <= cfg_rep_sel;
            e2_q   <= cfg_temp2_en;
            t1_q   <= cfg_t1_src;
        end else if (move) begin
            pos_q <= pos_nxt;
            if (wrap) begin
                nsel_q <= cfg_rep_sel;
                e2_q   <= cfg_temp2_en;
                t1_q   <= cfg_t1_src;
            end
        end
    end

    assign step_kind = info.kind;
    assign conv_src  = src_for(info.kind, t1_q);

    AST_HOLD_SELECT: assert property (@(posedge clk) disable iff (rst)
        (waiting && !conv_done) |=> ($stable(conv_src) && $stable(step_kind))); // R3
    AST_T2_NEEDS_E2: assert property (@(posedge clk) disable iff (rst)
        (conv_start && (step_kind == K_AZ_T2 || step_kind == K_TEMP2)) |-> e2_q); // R6
    AST_AZ_USES_SHORT: assert property (@(posedge clk) disable iff (rst)
        (step_kind == K_AZ_PRESS || step_kind == K_AZ_T1 || step_kind == K_AZ_T2)
            |-> (conv_src == SRC_SHORT)); // R9
    AST_PRESS_USES_BRIDGE: assert property (@(posedge clk) disable iff (rst)
        (step_kind == K_PRESS) |-> (conv_src == SRC_BRIDGE)); // R9

endmodule

// File: tb/sim_measure_cycle_seq.sv
`timescale 1ns/1ps
module sim_measure_cycle_seq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] cfg_rep_sel = 3'd1;
    logic       cfg_temp2_en = 1'b1;
    logic [1:0] cfg_t1_src = 2'd0;
    logic       conv_done = 1'b0;
    logic       conv_start;
    logic [2:0] conv_src;
    logic [2:0] step_kind;

    always #2.5 clk = ~clk;

    measure_cycle_seq #(.N_SEL_W(3)) u0 (
        .clk          (clk),
        .rst          (rst),
        .cfg_rep_sel  (cfg_rep_sel),
        .cfg_temp2_en (cfg_temp2_en),
        .cfg_t1_src   (cfg_t1_src),
        .conv_done    (conv_done),
        .conv_start   (conv_start),
        .conv_src     (conv_src),
        .step_kind    (step_kind)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // wanted inputs, applied at the falling edge inside tick()
    logic       w_rst = 1'b1;
    logic [2:0] w_sel = 3'd1;
    logic       w_e2 = 1'b1;
    logic [1:0] w_t1 = 2'd0;
    bit         stray = 0;

    // behavioural reference: 0 idle, 1 start cycle, 2 waiting
    int m_state = 0;
    int q[$];

    function automatic int t1_map(input int s);
        case (s)
            1: return 3;
            2: return 4;
            default: return 2;
        endcase
    endfunction

    function automatic int item(input int k, input int s);
        return k * 8 + s;
    endfunction

    task automatic push_group(input int n);
        for (int i = 0; i < n; i++) q.push_back(item(0, 0));
    endtask

    task automatic push_startup();
        q.push_back(item(0, 0));
        q.push_back(item(1, 1));
        q.push_back(item(2, 1));
        q.push_back(item(3, t1_map(int'(cfg_t1_src))));
        if (cfg_temp2_en) begin
            q.push_back(item(4, 1));
            q.push_back(item(5, 5));
        end
    endtask

    task automatic push_pass();
        int n;
        n = 1 << cfg_rep_sel;
        push_group(n); q.push_back(item(2, 1));
        push_group(n); q.push_back(item(3, t1_map(int'(cfg_t1_src))));
        push_group(n); q.push_back(item(1, 1));
        if (cfg_temp2_en) begin
            push_group(n); q.push_back(item(4, 1)); q.push_back(item(5, 5)); push_group(n);
        end
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic tick(input string tag);
        @(negedge clk);
        // compare outputs produced by the preceding rising edge
        if (rst) begin
            check("R1", "conv_start in reset", int'(conv_start), 0);
        end else begin
            check({tag, " R2"}, "conv_start", int'(conv_start), (m_state == 1) ? 1 : 0);
            if (m_state != 0 && q.size() > 0) begin
                check((m_state == 2) ? {tag, " R3 R10"} : {tag, " R10"}, "step_kind",
                      int'(step_kind), q[0] / 8);
                check((m_state == 2) ? {tag, " R3 R9"} : {tag, " R9"}, "conv_src",
                      int'(conv_src), q[0] % 8);
            end
        end
        // drive the inputs for the next rising edge
        rst          = w_rst;
        cfg_rep_sel  = w_sel;
        cfg_temp2_en = w_e2;
        cfg_t1_src   = w_t1;
        if (stray) conv_done = ($urandom % 2) == 0;
        else       conv_done = (m_state == 2) && (($urandom % 2) == 0);
        // advance the reference through that edge
        if (rst) begin
            m_state = 0;
            q.delete();
            push_startup();
        end else begin
            case (m_state)
                0: m_state = 1;
                1: m_state = 2;
                default: if (conv_done) begin
                    void'(q.pop_front());
                    if (q.size() == 0) push_pass();
                    m_state = 1;
                end
            endcase
        end
    endtask

    task automatic run(input string tag, input int cycles);
        for (int i = 0; i < cycles; i++) tick(tag);
    endtask

    initial begin
        // R1: reset state and first request
        w_rst = 1'b1;
        run("R1", 4);
        w_rst = 1'b0;
        run("R1", 3);
        // R4: start routine with branch enabled, G=2
        run("R4", 40);
        // R5: loop passes
        run("R5", 300);
        // R7: every group size, changed at arbitrary points (R8)
        for (int s = 0; s < 8; s++) begin
            w_sel = 3'(s);
            run("R7 R8", 1200 + (s * 300));
        end
        // R6: branch disabled, including a fresh start routine
        w_sel = 3'd1;
        w_e2 = 1'b0;
        run("R6", 300);
        w_rst = 1'b1;
        run("R1", 2);
        w_rst = 1'b0;
        run("R6 R4", 400);
        // R9: each temperature-1 source
        w_e2 = 1'b1;
        for (int t = 0; t < 4; t++) begin
            w_t1 = 2'(t);
            run("R9", 250);
        end
        // R8: configuration churn mid-pass
        for (int j = 0; j < 40; j++) begin
            w_e2  = ($urandom % 2) == 0;
            w_sel = 3'($urandom % 3);
            w_t1  = 2'($urandom % 4);
            run("R8", 37);
        end
        // R11: completion pulses outside the wait
        stray = 1;
        run("R11", 600);
        stray = 0;
        run("R11", 50);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule